// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block sits between a CPU and an on-chip flash macro and controls what a store-to-program-memory strobe does. Software first writes a five-bit command into the block's control register. That write arms one operation: buffer load, page erase, page write, lock-bit set, or re-enabling reads of the read-while-write (RWW) region. The armed command applies only if a store strobe arrives within a short window after the write. If no strobe comes, the command bits clear themselves.

A buffer load writes the R1:R0 word into a temporary page buffer. Erase and write hand a page number to an abstract flash model through a request/done handshake. If the target page is outside the RWW region, the CPU is halted until the operation ends. If the target page is inside the RWW region, a region-busy flag is raised instead. That flag stays set until a later read-enable command, issued once the flash is idle, clears it. Lock set passes R0 to the lock logic. A load-program-memory strobe shortly after lock-set arming returns either the lock byte or the fuse byte.

Top module: `flash_selfprog_ctrl`

## Requirements
- R1: Only the command values 5'b00001 (load), 5'b00011 (erase), 5'b00101 (write), 5'b01001 (lock) and 5'b10001 (read-enable) are accepted. In `regRdData`, bit 0 is enable, bit 1 erase, bit 2 write, bit 3 lock and bit 4 read-enable. An accepted write shows its value in `regRdData[4:0]` from the next cycle. Any other value leaves `regRdData` unchanged.
- R2: The armed command applies to a store strobe in any of the four cycles after the write cycle. A strobe in the fifth cycle has no effect, because the bits read zero from that cycle on.
- R3: A store strobe with a load armed raises `bufWrEn` in the same cycle, with `bufWrAddr = zAddr[PGB-1:1]` and `bufWrData = wordData`. `regRdData[4:0]` reads zero from the next cycle.
- R4: A store strobe with erase or write armed raises `flashReq` for one cycle. In that cycle, `flashPage = zAddr[ZW-1:PGB]` and `flashWrite` is 1 for write and 0 for erase. The command bits, including enable, stay set until the cycle after `flashDone`, and then read zero.
- R5: While an erase or write is in progress, every register write is ignored, including a read-enable write.
- R6: An erase or write to a page numbered `NRWW_FIRST` or higher holds `cpuHalt` high from the next cycle until the cycle after `flashDone`. An erase or write to a lower page instead sets `rwwBusy`, which is readable at `regRdData[6]`, and leaves `cpuHalt` low.
- R7: `rwwBusy` clears only on a store strobe with read-enable armed. `flashDone` alone does not clear it.
- R8: If a read-enable write is accepted while buffer loading is in progress, `bufClear` is raised in that cycle. Buffer loading is in progress after at least one buffer word has been written and before the next erase, write or abort. In any other state, a read-enable write raises no `bufClear`.
- R9: A store strobe with lock armed raises `lockWrEn`, with `lockWrData = wordData[7:0]`. A load strobe in cycles 1 to 3 after lock arming raises `lpmValid`, with `lpmData` equal to `lockBits` when `zAddr[0]` is 1 and `fuseBits` when it is 0. In cycle 4, a load strobe gives no `lpmValid`.
- R10: `regRdData` bits 5 and 7 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| regWrEn | input | 1 | Control register write |
| regWrData | input | 5 | Command value |
| regRdData | output | 8 | Register readback |
| storeStb | input | 1 | Store-to-program-memory strobe |
| lpmStb | input | 1 | Load-program-memory strobe |
| zAddr | input | ZW | Z byte address |
| wordData | input | 16 | R1:R0 word |
| lockBits | input | 8 | Current lock byte |
| fuseBits | input | 8 | Current fuse byte |
| flashDone | input | 1 | Flash operation complete pulse |
| flashReq | output | 1 | Start erase/write |
| flashWrite | output | 1 | 1 write, 0 erase |
| flashPage | output | ZW-PGB | Target page |
| bufWrEn | output | 1 | Page buffer word write |
| bufWrAddr | output | PGB-1 | Buffer word index |
| bufWrData | output | 16 | Buffer word |
| bufClear | output | 1 | Discard buffer contents |
| lockWrEn | output | 1 | Lock byte write |
| lockWrData | output | 8 | Lock byte value |
| lpmValid | output | 1 | Lock/fuse read result valid |
| lpmData | output | 8 | Lock/fuse read result |
| cpuHalt | output | 1 | Stall the CPU |
| rwwBusy | output | 1 | RWW region unreadable |

## Verification
The most likely internal faults are a window counter that is off by one or a command register that clears at the wrong time. A wrong counter shows at the ports on the very next strobe, in the fourth or fifth cycle after a write: `bufWrEn`, `flashReq` or `lockWrEn` either fires when it should not or stays silent when it should fire. The same fault shows as a `regRdData` value that is nonzero one cycle too long. A lost busy state shows as `cpuHalt` dropping before `flashDone`, or as a write accepted during an operation and visible in the readback one cycle later. A wrong loading flag shows only at the next read-enable write, through `bufClear`.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  typedef enum logic [4:0] {
    CMD_IDLE  = 5'b00000,
    CMD_LOAD  = 5'b00001,
    CMD_ERASE = 5'b00011,
    CMD_WRITE = 5'b00101,
    CMD_LOCK  = 5'b01001,
    CMD_RWWRE = 5'b10001
  } fspCmd_e;

  typedef struct packed {
    logic bufWr;
    logic bufClr;
    logic flashGo;
    logic lockWr;
    logic lpmRd;
    logic rwwClr;
  } fspStb_t;

  function automatic logic isLegalCmd(input logic [4:0] v);
    case (v)
      CMD_LOAD, CMD_ERASE, CMD_WRITE, CMD_LOCK, CMD_RWWRE: isLegalCmd = 1'b1;
      default: isLegalCmd = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/fsp_ctrl.sv
module fsp_ctrl
  import fsp_pkg::*;
#(
  parameter int WIN     = 4,
  parameter int LPM_WIN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       regWrEn,
  input  logic [4:0] regWrData,
  input  logic       storeStb,
  input  logic       lpmStb,
  input  logic       flashDone,
  input  logic       targetNrww,
  output fspCmd_e    cmdQ,
  output logic       opBusy,
  output logic       cpuHalt,
  output logic       rwwBusy,
  output fspStb_t    stb
);
  localparam int CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] WIN_LOAD = CW'(WIN);
  localparam logic [CW-1:0] LPM_MIN  = CW'(WIN - LPM_WIN);

  logic [CW-1:0] winCnt;
  logic loading;
  logic armed, wrOk, accept;

  assign armed  = (cmdQ != CMD_IDLE) && !opBusy;
  assign wrOk   = regWrEn && isLegalCmd(regWrData) && !opBusy;
  assign accept = storeStb && armed && !wrOk;

  always_comb begin
    stb         = '0;
    stb.bufWr   = accept && (cmdQ == CMD_LOAD);
    stb.flashGo = accept && ((cmdQ == CMD_ERASE) || (cmdQ == CMD_WRITE));
    stb.lockWr  = accept && (cmdQ == CMD_LOCK);
    stb.rwwClr  = accept && (cmdQ == CMD_RWWRE);
    stb.lpmRd   = lpmStb && armed && (cmdQ == CMD_LOCK) && (winCnt > LPM_MIN);
    stb.bufClr  = wrOk && (regWrData == CMD_RWWRE) && loading;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdQ    <= CMD_IDLE;
      winCnt  <= '0;
      opBusy  <= 1'b0;
      cpuHalt <= 1'b0;
    end else if (opBusy) begin
      if (flashDone) begin
        opBusy  <= 1'b0;
        cpuHalt <= 1'b0;
        cmdQ    <= CMD_IDLE;
      end
    end else if (wrOk) begin
      cmdQ   <= fspCmd_e'(regWrData);
      winCnt <= WIN_LOAD;
    end else if (accept) begin
      if (stb.flashGo) begin
        opBusy  <= 1'b1;
        cpuHalt <= targetNrww;
      end else begin
        cmdQ <= CMD_IDLE;
      end
    end else if (armed) begin
      if (winCnt == CW'(1)) cmdQ <= CMD_IDLE;
      else winCnt <= winCnt - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rwwBusy <= 1'b0;
      loading <= 1'b0;
    end else begin
      if (stb.flashGo && !targetNrww) rwwBusy <= 1'b1;
      else if (stb.rwwClr) rwwBusy <= 1'b0;
      if (stb.flashGo || stb.bufClr) loading <= 1'b0;
      else if (stb.bufWr) loading <= 1'b1;
    end
  end

  // R4 / R5: enable bit stays up through an operation
  p_enable_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    opBusy |-> cmdQ[0]);
  // R5: command frozen while busy and not done
  p_busy_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    opBusy && !flashDone |=> opBusy && $stable(cmdQ));
  // R6: halt held until done
  p_halt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpuHalt && !flashDone |=> cpuHalt);
  // R7: busy flag falls only after a read-enable store
  p_rww_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rwwBusy) |-> $past(storeStb) && ($past(cmdQ) == CMD_RWWRE));
  // R3: load is one-shot
  p_load_oneshot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stb.bufWr |=> cmdQ == CMD_IDLE);
endmodule

// File: rtl/fsp_dpath.sv
module fsp_dpath
  import fsp_pkg::*;
#(
  parameter int ZW         = 16,
  parameter int PGB        = 6,
  parameter int NRWW_FIRST = 768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fspStb_t           stb,
  input  fspCmd_e           cmdQ,
  input  logic [ZW-1:0]     zAddr,
  input  logic [15:0]       wordData,
  input  logic [7:0]        lockBits,
  input  logic [7:0]        fuseBits,
  output logic              targetNrww,
  output logic              flashReq,
  output logic              flashWrite,
  output logic [ZW-PGB-1:0] flashPage,
  output logic              bufWrEn,
  output logic [PGB-2:0]    bufWrAddr,
  output logic [15:0]       bufWrData,
  output logic              bufClear,
  output logic              lockWrEn,
  output logic [7:0]        lockWrData,
  output logic              lpmValid,
  output logic [7:0]        lpmData
);
  localparam int PW = ZW - PGB;
  localparam logic [PW-1:0] NRWW_PG = PW'(NRWW_FIRST);

  assign flashPage  = zAddr[ZW-1:PGB];
  assign targetNrww = flashPage >= NRWW_PG;
  assign flashReq   = stb.flashGo;
  assign flashWrite = (cmdQ == CMD_WRITE);
  assign bufWrEn    = stb.bufWr;
  assign bufWrAddr  = zAddr[PGB-1:1];
  assign bufWrData  = wordData;
  assign bufClear   = stb.bufClr;
  assign lockWrEn   = stb.lockWr;
  assign lockWrData = wordData[7:0];
  assign lpmValid   = stb.lpmRd;
  assign lpmData    = zAddr[0] ? lockBits : fuseBits;

  // R8: an abort never coincides with a buffer write
  p_clear_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bufClear |-> !bufWrEn);
  // R4: a flash request is a single-cycle pulse
  p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flashReq |=> !flashReq);
endmodule

// File: rtl/flash_selfprog_ctrl.sv
module flash_selfprog_ctrl
  import fsp_pkg::*;
#(
  parameter int ZW         = 16,
  parameter int PGB        = 6,
  parameter int NRWW_FIRST = 768,
  parameter int WIN        = 4,
  parameter int LPM_WIN    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [4:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              storeStb,
  input  logic              lpmStb,
  input  logic [ZW-1:0]     zAddr,
  input  logic [15:0]       wordData,
  input  logic [7:0]        lockBits,
  input  logic [7:0]        fuseBits,
  input  logic              flashDone,
  output logic              flashReq,
  output logic              flashWrite,
  output logic [ZW-PGB-1:0] flashPage,
  output logic              bufWrEn,
  output logic [PGB-2:0]    bufWrAddr,
  output logic [15:0]       bufWrData,
  output logic              bufClear,
  output logic              lockWrEn,
  output logic [7:0]        lockWrData,
  output logic              lpmValid,
  output logic [7:0]        lpmData,
  output logic              cpuHalt,
  output logic              rwwBusy
);
  fspCmd_e cmdQ;
  fspStb_t stb;
  logic    opBusy, targetNrww;

  fsp_ctrl #(.WIN(WIN), .LPM_WIN(LPM_WIN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regWrData(regWrData),
    .storeStb(storeStb), .lpmStb(lpmStb), .flashDone(flashDone),
    .targetNrww(targetNrww), .cmdQ(cmdQ), .opBusy(opBusy),
    .cpuHalt(cpuHalt), .rwwBusy(rwwBusy), .stb(stb)
  );

  fsp_dpath #(.ZW(ZW), .PGB(PGB), .NRWW_FIRST(NRWW_FIRST)) u_dpath (
    .clk(clk), .rst_n(rst_n), .stb(stb), .cmdQ(cmdQ), .zAddr(zAddr),
    .wordData(wordData), .lockBits(lockBits), .fuseBits(fuseBits),
    .targetNrww(targetNrww), .flashReq(flashReq), .flashWrite(flashWrite),
    .flashPage(flashPage), .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr),
    .bufWrData(bufWrData), .bufClear(bufClear), .lockWrEn(lockWrEn),
    .lockWrData(lockWrData), .lpmValid(lpmValid), .lpmData(lpmData)
  );

  assign regRdData = {1'b0, rwwBusy, 1'b0, cmdQ};

  // R10: reserved readback bits stay zero
  p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
    regRdData[7] == 1'b0 && regRdData[5] == 1'b0);
endmodule

// File: tb/flash_selfprog_ctrl_tb.sv
module flash_selfprog_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] LOCKV = 8'hA5;
  localparam logic [7:0] FUSEV = 8'h3C;

  logic clk = 0, rst_n = 0;
  logic regWrEn = 0, storeStb = 0, lpmStb = 0, flashDone = 0;
  logic [4:0] regWrData = '0;
  logic [15:0] zAddr = '0, wordData = '0;
  logic [7:0] regRdData, lockWrData, lpmData;
  logic flashReq, flashWrite, bufWrEn, bufClear, lockWrEn, lpmValid, cpuHalt, rwwBusy;
  logic [9:0] flashPage;
  logic [4:0] bufWrAddr;
  logic [15:0] bufWrData;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_selfprog_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .storeStb(storeStb), .lpmStb(lpmStb), .zAddr(zAddr),
    .wordData(wordData), .lockBits(LOCKV), .fuseBits(FUSEV), .flashDone(flashDone),
    .flashReq(flashReq), .flashWrite(flashWrite), .flashPage(flashPage),
    .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr), .bufWrData(bufWrData),
    .bufClear(bufClear), .lockWrEn(lockWrEn), .lockWrData(lockWrData),
    .lpmValid(lpmValid), .lpmData(lpmData), .cpuHalt(cpuHalt), .rwwBusy(rwwBusy)
  );

  function automatic logic legalPat(input logic [4:0] v);
    return v == 5'b00001 || v == 5'b00011 || v == 5'b00101 ||
           v == 5'b01001 || v == 5'b10001;
  endfunction

  function automatic logic [15:0] mkZ(input int page, input int ofs);
    return {10'(page), 6'(ofs)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    regWrEn = 0; storeStb = 0; lpmStb = 0; flashDone = 0;
  endtask

  task automatic wr(input logic [4:0] v);
    cyc(); regWrEn = 1; regWrData = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc(); #1;
    chk("R1 reset readback", regRdData, 0);
    chk("R6 reset halt/busy", {cpuHalt, rwwBusy}, 0);

    // every pattern, then timeout
    for (int p = 0; p < 32; p++) begin
      wr(5'(p)); cyc(); #1;
      chk("R1 pattern accept", regRdData, legalPat(5'(p)) ? 8'(p) : 8'h00);
      chk("R10 reserved zero", {regRdData[7], regRdData[5]}, 0);
      idle(3); #1;
      chk("R2 still armed cycle4", regRdData, legalPat(5'(p)) ? 8'(p) : 8'h00);
      cyc(); #1;
      chk("R2 cleared after window", regRdData, 0);
    end

    // load at cycle 4 (accepted) vs cycle 5 (ignored)
    wr(5'b00001); idle(3);
    cyc(); storeStb = 1; zAddr = mkZ(7, 6'h2B); wordData = 16'hBEEF; #1;
    chk("R2 store at cycle 4", bufWrEn, 1);
    chk("R3 buffer addr", bufWrAddr, 5'h15);
    chk("R3 buffer data", bufWrData, 16'hBEEF);
    cyc(); #1;
    chk("R3 enable clears", regRdData, 0);
    wr(5'b00001); idle(4);
    cyc(); storeStb = 1; #1;
    chk("R2 store at cycle 5", bufWrEn, 0);

    // abort of loading (one word loaded above)
    wr(5'b10001); #1;
    chk("R8 abort clears buffer", bufClear, 1);
    idle(6);
    wr(5'b10001); #1;
    chk("R8 no abort when idle", bufClear, 0);
    idle(6);

    // erase in RWW region
    wr(5'b00011); cyc(); storeStb = 1; zAddr = mkZ(5, 0); #1;
    chk("R4 erase req", {flashReq, flashWrite}, 2'b10);
    chk("R4 erase page", flashPage, 5);
    cyc(); #1;
    chk("R6 rww no halt", {cpuHalt, rwwBusy}, 2'b01);
    chk("R4 bits held", regRdData, 8'h43);
    wr(5'b10001); #1;
    chk("R5 no abort while busy", bufClear, 0);
    cyc(); #1;
    chk("R5 write ignored", regRdData, 8'h43);
    idle(3);
    cyc(); flashDone = 1;
    cyc(); #1;
    chk("R4 done clears", regRdData, 8'h40);
    chk("R7 busy survives done", rwwBusy, 1);
    wr(5'b10001); cyc(); storeStb = 1; cyc(); #1;
    chk("R7 read-enable clears", {rwwBusy, regRdData}, 9'h000);

    // write in halting region, with a load in progress beforehand
    wr(5'b00001); cyc(); storeStb = 1; zAddr = mkZ(900, 4); cyc();
    wr(5'b00101); cyc(); storeStb = 1; zAddr = mkZ(900, 0); #1;
    chk("R4 write req", {flashReq, flashWrite}, 2'b11);
    chk("R4 write page", flashPage, 900);
    cyc(); #1;
    chk("R6 halt set", {cpuHalt, rwwBusy}, 2'b10);
    idle(4); #1;
    chk("R6 halt held", cpuHalt, 1);
    cyc(); flashDone = 1; #1;
    chk("R6 halt until done", cpuHalt, 1);
    cyc(); #1;
    chk("R6 halt released", {cpuHalt, regRdData}, 9'h000);
    wr(5'b10001); #1;
    chk("R8 write ended loading", bufClear, 0);
    idle(6);

    // lock and lock/fuse readback
    wr(5'b01001); cyc(); lpmStb = 1; zAddr = 16'h0001; #1;
    chk("R9 lpm lock k1", {lpmValid, lpmData}, {1'b1, LOCKV});
    cyc(); lpmStb = 1; zAddr = 16'h0000; #1;
    chk("R9 lpm fuse k2", {lpmValid, lpmData}, {1'b1, FUSEV});
    cyc(); lpmStb = 1; #1;
    chk("R9 lpm k3", lpmValid, 1);
    cyc(); lpmStb = 1; storeStb = 1; wordData = 16'h12C3; #1;
    chk("R9 lpm k4 none", lpmValid, 0);
    chk("R9 lock write", {lockWrEn, lockWrData}, {1'b1, 8'hC3});
    cyc(); #1;
    chk("R9 lock clears", regRdData, 0);

    // random loads with random strobe delay
    for (int n = 0; n < 24; n++) begin
      int k;
      logic [15:0] z, d;
      k = 1 + int'($urandom % 5);
      z = 16'($urandom); d = 16'($urandom);
      wr(5'b00001); idle(k - 1);
      cyc(); storeStb = 1; zAddr = z; wordData = d; #1;
      chk("R2 random window", bufWrEn, (k <= 4) ? 1 : 0);
      if (k <= 4) chk("R3 random word", {bufWrAddr, bufWrData}, {z[5:1], d});
      idle(6);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule